// File: doc/BRIEF.md
# Periodic ADC Update Sequencer

This block schedules conversions for a three-input, 8-bit successive-approximation converter and owns the result register that a host reads. A two-bit select field picks the input or switches the converter off. When the converter is switched on, a first conversion is started after a short, fixed delay. After that, conversions repeat on a fixed period. All delays are counted in strobes of a time-base tick, so the same block serves any tick rate.

A status flag warns the host that a result-register write is close, so that it can time its reads. While a host read is in progress, the result register is frozen. A result that arrives during the read waits in a one-entry buffer, and a newer arrival replaces an older one. The buffer drains when the read completes or is aborted by raising the chip select.

The SAR engine handshake uses plain pulses with no back-pressure. The block issues a one-cycle start with the channel number. It accepts a code on a one-cycle done pulse, but only while a conversion it started is still outstanding. The block never stalls the engine, and the engine must not hold off the block.

Top module: `adc_update_seq`

## Requirements
- R1: With select 00 the block issues no start, ignores done pulses, holds the flag at 0 from the next cycle and discards any buffered result. The result register keeps its last value.
- R2: When the select changes from 00 to a nonzero value, the first start is issued in the cycle after the FIRST_TICKS-th tick strobe counted from the next cycle onward. Select 01, 10 and 11 map to channel numbers 0, 1 and 2.
- R3: After each start, the next start follows exactly PERIOD_TICKS tick strobes later. A change between two nonzero selections does not restart this schedule.
- R4: The channel number sent with a start is taken from the select value at the scheduled moment, so a mid-period change takes effect at the next scheduled conversion.
- R5: A start is a single-cycle pulse, and a done pulse is accepted only while a started conversion is outstanding.
- R6: An accepted code is written unchanged to the result register on the accepting edge when no read is blocking. 00h stands for ground and FFh for full scale.
- R7: The flag is 1 exactly when the block is on and at least one of these holds: at most WARN_TICKS ticks remain before the next start, a conversion is outstanding, or a result is buffered. A 0 therefore guarantees more than WARN_TICKS ticks before any write.
- R8: A read begins on a read strobe while the chip select (active low) is 0, and it ends on a read-done pulse. While it is in progress, the result register does not change.
- R9: Raising the chip select during a read aborts it, and a buffered result is written on that same edge.
- R10: A code accepted during a blocked read replaces any older buffered code, and only the newest is written when the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base strobe, one cycle per tick |
| chan_sel_i | input | 2 | Input select; 00 = converter off |
| rd_stb_i | input | 1 | Host read of the result register begins |
| rd_done_i | input | 1 | Host read completes |
| cs_n_i | input | 1 | Active-low chip select; high aborts a read |
| sar_start_o | output | 1 | One-cycle conversion start |
| sar_chan_o | output | 2 | Channel number for the started conversion |
| sar_done_i | input | 1 | Conversion finished pulse |
| sar_code_i | input | 8 | Converted code, valid with sar_done_i |
| result_o | output | 8 | Result register |
| busy_o | output | 1 | Update-imminent status flag |

## Verification
The hardest situation to reach is a conversion finishing while a read is held open, and then a second one overwriting that buffered code before the read is released or aborted. With the tick parameters scaled down, the stimulus holds one read open across several periods, releases it once by abort and once by completion, and switches the converter off with a code still buffered. Random phases then mix reads, select changes and tick gaps, and a bench model tracks the schedule, the buffer and the flag every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CODE_W = 8;
  localparam logic [1:0] SEL_OFF = 2'b00;

  typedef logic [1:0] sel_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic logic [1:0] chan_of(input sel_t sel);
    return sel - 2'd1;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int FIRST_TICKS  = 400,
  parameter int PERIOD_TICKS = 10000,
  parameter int WARN_TICKS   = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic enable_i,
  output logic fire_o,
  output logic warn_o,
  output logic on_o
);
  localparam int MAXV = (FIRST_TICKS > PERIOD_TICKS) ? FIRST_TICKS : PERIOD_TICKS;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q;
  logic          on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q <= enable_i;
      if (!enable_i)
        cnt_q <= '0;
      else if (!on_q)
        cnt_q <= CW'(FIRST_TICKS);
      else if (tick_i) begin
        if (cnt_q <= CW'(1))
          cnt_q <= CW'(PERIOD_TICKS);
        else
          cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign fire_o = enable_i & on_q & tick_i & (cnt_q <= CW'(1));
  assign warn_o = on_q & (cnt_q <= CW'(WARN_TICKS));
  assign on_o   = on_q;

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (cnt_q != '0 && cnt_q <= CW'(MAXV)));
endmodule

// File: rtl/adc_seq_readlock.sv
module adc_seq_readlock (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb_i,
  input  logic rd_done_i,
  input  logic cs_n_i,
  output logic blocked_o
);
  logic active_q;

  assign blocked_o = active_q & ~rd_done_i & ~cs_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_q <= 1'b0;
    else if (active_q)
      active_q <= blocked_o;
    else
      active_q <= rd_stb_i & ~cs_n_i;
  end

  p_abort_ends_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cs_n_i) |=> !active_q);
endmodule

// File: rtl/adc_seq_resbuf.sv
module adc_seq_resbuf
  import adc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush_i,
  input  logic  accept_i,
  input  code_t code_i,
  input  logic  blocked_i,
  output code_t result_o,
  output logic  pend_o
);
  code_t result_q, pend_q;
  logic  pend_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (flush_i) begin
      pend_v_q <= 1'b0;
    end else if (accept_i) begin
      if (blocked_i) begin
        pend_q   <= code_i;
        pend_v_q <= 1'b1;
      end else begin
        result_q <= code_i;
        pend_v_q <= 1'b0;
      end
    end else if (pend_v_q && !blocked_i) begin
      result_q <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign result_o = result_q;
  assign pend_o   = pend_v_q;

  p_frozen_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_i |=> $stable(result_q));
  p_flush_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !pend_v_q);
endmodule

// File: rtl/adc_update_seq.sv
module adc_update_seq
  import adc_seq_pkg::*;
#(
  parameter int FIRST_TICKS  = 400,
  parameter int PERIOD_TICKS = 10000,
  parameter int WARN_TICKS   = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] chan_sel_i,
  input  logic       rd_stb_i,
  input  logic       rd_done_i,
  input  logic       cs_n_i,
  output logic       sar_start_o,
  output logic [1:0] sar_chan_o,
  input  logic       sar_done_i,
  input  logic [7:0] sar_code_i,
  output logic [7:0] result_o,
  output logic       busy_o
);
  logic enable, fire, warn, on, blocked, pend;
  logic conv_busy_q, start_q, issue, accept;
  logic [1:0] chan_q;

  assign enable = (chan_sel_i != SEL_OFF);
  assign issue  = fire & ~conv_busy_q;
  assign accept = sar_done_i & conv_busy_q & enable;

  adc_seq_timer #(
    .FIRST_TICKS (FIRST_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS),
    .WARN_TICKS  (WARN_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .enable_i(enable),
    .fire_o  (fire),
    .warn_o  (warn),
    .on_o    (on)
  );

  adc_seq_readlock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb_i (rd_stb_i),
    .rd_done_i(rd_done_i),
    .cs_n_i   (cs_n_i),
    .blocked_o(blocked)
  );

  adc_seq_resbuf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (~enable),
    .accept_i (accept),
    .code_i   (sar_code_i),
    .blocked_i(blocked),
    .result_o (result_o),
    .pend_o   (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_busy_q <= 1'b0;
      start_q     <= 1'b0;
      chan_q      <= '0;
    end else begin
      start_q <= issue;
      if (issue)
        chan_q <= chan_of(chan_sel_i);
      if (!enable)
        conv_busy_q <= 1'b0;
      else if (issue)
        conv_busy_q <= 1'b1;
      else if (accept)
        conv_busy_q <= 1'b0;
    end
  end

  assign sar_start_o = start_q;
  assign sar_chan_o  = chan_q;
  assign busy_o      = on & (warn | conv_busy_q | pend);

  p_start_needs_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sar_start_o |-> $past(chan_sel_i != SEL_OFF));
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel_i == SEL_OFF) |=> !busy_o);
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sar_start_o |=> !sar_start_o);
  p_warned_before_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sar_start_o |-> $past(busy_o));
endmodule

// File: tb/adc_update_seq_bench.sv
module adc_update_seq_bench;
  localparam int FIRST  = 6;
  localparam int PERIOD = 20;
  localparam int WARN   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, rd_stb = 1'b0, rd_done = 1'b0, cs_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sar_start, sar_done = 1'b0, busy;
  logic [1:0] sar_chan;
  logic [7:0] sar_code = 8'h00, result;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench model state
  bit on_m = 0, first = 0, outst = 0, pend_v = 0, rd_act = 0, prev_start = 0;
  int tcount = 0, lat = 0;
  logic [7:0] exp_res = 8'h00, pend = 8'h00, last_code = 8'h00;

  always #2 clk = ~clk;

  adc_update_seq #(.FIRST_TICKS(FIRST), .PERIOD_TICKS(PERIOD), .WARN_TICKS(WARN)) u_adc_update_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .chan_sel_i(sel),
    .rd_stb_i(rd_stb), .rd_done_i(rd_done), .cs_n_i(cs_n),
    .sar_start_o(sar_start), .sar_chan_o(sar_chan),
    .sar_done_i(sar_done), .sar_code_i(sar_code),
    .result_o(result), .busy_o(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int target_of(input bit f);
    return f ? FIRST : PERIOD;
  endfunction

  // consume the inputs applied in the last cycle, then compare outputs
  task automatic step();
    bit p_on, blk, acc, exp_busy;
    @(posedge clk);
    @(negedge clk);
    p_on = (sel != 2'b00);
    if (p_on && on_m && tick) tcount++;
    blk = rd_act && !rd_done && !cs_n;
    acc = p_on && outst && sar_done;
    if (!p_on) begin
      pend_v = 0; outst = 0;
    end else if (acc) begin
      if (blk) begin pend = sar_code; pend_v = 1; end
      else begin exp_res = sar_code; pend_v = 0; end
      outst = 0;
    end else if (pend_v && !blk) begin
      exp_res = pend; pend_v = 0;
    end
    rd_act = rd_act ? blk : (rd_stb && !cs_n);
    if (p_on && !on_m) begin tcount = 0; first = 1; end
    on_m = p_on;
    if (sar_start) begin
      chk("R1 start only when on", int'(p_on), 1);
      chk(first ? "R2 first delay" : "R3 period", tcount, target_of(first));
      chk("R4 channel", int'(sar_chan), int'(sel) - 1);
      if (prev_start) chk("R5 single pulse", 1, 0);
      tcount = 0; first = 0; outst = 1; lat = 1 + int'($urandom % 3);
    end else if (p_on && tcount >= target_of(first)) begin
      chk("R3 missed start", tcount, target_of(first) - 1);
    end
    prev_start = sar_start;
    exp_busy = p_on && ((target_of(first) - tcount) <= WARN || outst || pend_v);
    chk("R7 flag", int'(busy), int'(exp_busy));
    chk(blk ? "R8 frozen" : "R6 result", int'(result), int'(exp_res));
    sar_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        sar_done = 1'b1;
        sar_code = 8'($urandom);
        last_code = sar_code;
      end
    end
    tick = 1'b0; rd_stb = 1'b0; rd_done = 1'b0;
  endtask

  task automatic set_sel(input logic [1:0] s);
    sel = s;
    tick = 1'b0;
    step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
    end
  endtask

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 reset result", int'(result), 0);
    chk("R7 reset flag", int'(busy), 0);
    chk("R5 reset start", int'(sar_start), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // enable on input 1 and run through first and periodic conversions
    set_sel(2'b01);
    run(50);
    set_sel(2'b11);      // mid-period change, used at next slot (R4)
    run(25);

    // read held across several conversions, then aborted (R9, R10)
    rd_stb = 1'b1; step();
    run(60);
    chk("R10 pending not yet written", int'(result), int'(exp_res));
    cs_n = 1'b1; step();
    chk("R9 abort writes newest", int'(result), int'(last_code));
    cs_n = 1'b0;

    // read completed with rd_done (R8)
    rd_stb = 1'b1; step();
    run(30);
    rd_done = 1'b1; step();
    chk("R8 written after read end", int'(result), int'(last_code));

    // switch off while a code is buffered (R1)
    rd_stb = 1'b1; step();
    for (int i = 0; i < 200 && !pend_v; i++) begin tick = 1'b1; step(); end
    held = result;
    set_sel(2'b00);
    chk("R1 flag cleared", int'(busy), 0);
    rd_done = 1'b1; step();
    chk("R1 result kept, pending dropped", int'(result), int'(held));
    sar_done = 1'b1; sar_code = ~held; step();
    chk("R1 stray done ignored", int'(result), int'(held));
    run(40);
    chk("R1 no activity while off", int'(result), int'(held));

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 60 == 0) begin
        sel = 2'($urandom);
        tick = 1'b0;
      end else begin
        tick = ($urandom % 3 != 0);
      end
      rd_stb  = ($urandom % 6 == 0);
      rd_done = ($urandom % 12 == 0);
      cs_n    = ($urandom % 20 == 0);
      step();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule